// File: doc/BRIEF.md
# Single-Cycle Accumulator Core

This block is a small processor built around one accumulator. A program counter addresses a built-in program store. On every rising clock edge the core fetches the word at that address, decodes it and completes it. It has four general registers, an accumulator and a zero flag. The instruction set has five operations:

- an unconditional jump;
- a store of the accumulator into a register;
- an add of an immediate constant;
- an AND of a register into the accumulator;
- a branch taken only when the zero flag is set.

Only the jump and a taken branch redirect the program counter. Every other word, including unassigned opcodes, falls through to the next address.

The program counter, the accumulator, the zero flag and all four registers are brought out on debug ports, so the surrounding logic can watch the program run. Reset is asserted asynchronously through an active-low pin. Its release is synchronised inside the block, so execution begins a fixed number of edges after the pin rises.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low, and from the moment it falls, `dbg_pc`, `dbg_acc`, `dbg_zero` and `dbg_regs` are all zero.
- R2: With the default two-stage release synchroniser, the state stays at its reset value through the first two rising edges after `rst_n` rises. The word at address 0 executes on the third rising edge.
- R3: Exactly one instruction completes per rising edge once running. Instruction words are 16 bits: opcode in bits 15:12, register index in bits 11:10, bits 9:8 unused, and an 8-bit immediate or target address in bits 7:0.
- R4: Opcode 1 (jump) loads the program counter with bits 7:0 of the word.
- R5: Opcode 2 (store) copies the accumulator into the register selected by bits 11:10, leaving the accumulator and zero flag unchanged.
- R6: Opcode 3 (add immediate) replaces the accumulator with the accumulator plus bits 7:0, modulo 256.
- R7: Opcode 4 (AND register) replaces the accumulator with the accumulator ANDed with the selected register.
- R8: Opcode 5 (branch if zero) loads the program counter from bits 7:0 when the zero flag is set, and otherwise advances it by one.
- R9: The zero flag changes only when the accumulator is written (opcodes 3 and 4). It is then set exactly when the new accumulator value is zero.
- R10: Opcodes 0 and 6 to 15 change neither the accumulator, the zero flag nor any register, whatever their other fields hold.
- R11: Every instruction other than a jump or a taken branch advances the program counter by one, modulo 256, so address 255 is followed by address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| dbg_pc | output | 8 | Current program counter |
| dbg_acc | output | 8 | Current accumulator |
| dbg_zero | output | 1 | Current zero flag |
| dbg_regs | output | 32 | Register file, register i in bits 8*i+7:8*i |

## Verification
The built-in program targets several corner cases:

- It adds a constant that carries the accumulator past 255 to exactly zero. A core without the modulo wrap, or with a flag computed from the old value, would then skip the taken branch that follows.
- It stores, and runs unassigned opcodes whose other fields are non-zero, directly after a zero result. A core that updates the flag on those words, or decodes stray fields, would change the path of the later branches.
- It branches to the top of the address space. Execution must then wrap from 255 to 0, and a core that saturates or stalls there loses the second pass through the program.
- Reset is asserted in the middle of a run. This checks that clearing is immediate and that the three-edge release latency is repeated exactly.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  // Datapath and instruction geometry
  localparam int DATA_W    = 8;
  localparam int PC_W      = 8;
  localparam int REG_CNT   = 4;
  localparam int REG_IDX_W = $clog2(REG_CNT);
  localparam int OP_W      = 4;
  localparam int INSTR_W   = 16;
  localparam int FIELD_W   = DATA_W;
  localparam int RIDX_LSB  = INSTR_W - OP_W - REG_IDX_W;
  localparam int PAD_W     = RIDX_LSB - FIELD_W;
  localparam int REGS_W    = REG_CNT * DATA_W;

  // Opcode values
  localparam logic [OP_W-1:0] OPC_NOP  = 4'h0;
  localparam logic [OP_W-1:0] OPC_JMP  = 4'h1;
  localparam logic [OP_W-1:0] OPC_STR  = 4'h2;
  localparam logic [OP_W-1:0] OPC_ADDI = 4'h3;
  localparam logic [OP_W-1:0] OPC_ANDR = 4'h4;
  localparam logic [OP_W-1:0] OPC_BZ   = 4'h5;

  // Decoded control bundle
  typedef struct packed {
    logic load_pc;  // redirect PC to the address field
    logic acc_we;   // accumulator and zero flag are written
    logic use_add;  // accumulator source: 1 = sum, 0 = AND
    logic reg_we;   // register file write of the accumulator
  } ctrl_t;

  function automatic logic [INSTR_W-1:0] enc(input logic [OP_W-1:0]      op,
                                             input logic [REG_IDX_W-1:0] r,
                                             input logic [FIELD_W-1:0]   f);
    return {op, r, {PAD_W{1'b0}}, f};
  endfunction

  // Fixed program contents; unlisted addresses hold opcode 0
  function automatic logic [INSTR_W-1:0] prog_word(input logic [PC_W-1:0] a);
    logic [INSTR_W-1:0] w;
    case (a)
      8'h00: w = enc(OPC_ADDI, 2'd0, 8'h05);
      8'h01: w = enc(OPC_STR,  2'd1, 8'h00);
      8'h02: w = enc(OPC_ADDI, 2'd0, 8'hFB);
      8'h03: w = enc(OPC_BZ,   2'd0, 8'h06);
      8'h04: w = enc(OPC_ADDI, 2'd0, 8'h01);
      8'h05: w = enc(OPC_NOP,  2'd3, 8'hFF);
      8'h06: w = enc(OPC_STR,  2'd2, 8'h00);
      8'h07: w = enc(OPC_ADDI, 2'd0, 8'h0F);
      8'h08: w = enc(OPC_ANDR, 2'd1, 8'h00);
      8'h09: w = enc(OPC_BZ,   2'd0, 8'h00);
      8'h0A: w = enc(OPC_ANDR, 2'd2, 8'h00);
      8'h0B: w = enc(4'hE,     2'd1, 8'h33);
      8'h0C: w = enc(OPC_ADDI, 2'd0, 8'h3C);
      8'h0D: w = enc(OPC_STR,  2'd3, 8'h00);
      8'h0E: w = enc(OPC_ADDI, 2'd0, 8'hC4);
      8'h0F: w = enc(OPC_STR,  2'd0, 8'h00);
      8'h10: w = enc(OPC_ADDI, 2'd0, 8'h80);
      8'h11: w = enc(OPC_STR,  2'd0, 8'h00);
      8'h12: w = enc(OPC_JMP,  2'd0, 8'h14);
      8'h13: w = enc(OPC_ADDI, 2'd0, 8'h01);
      8'h14: w = enc(OPC_BZ,   2'd0, 8'h00);
      8'h15: w = enc(4'h9,     2'd2, 8'hAA);
      8'h16: w = enc(OPC_ANDR, 2'd3, 8'h00);
      8'h17: w = enc(OPC_BZ,   2'd0, 8'hFD);
      8'hFE: w = enc(OPC_ADDI, 2'd0, 8'h07);
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run_o
);

  generate
    if (STAGES <= 1) begin : g_single
      logic run_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
      end
      assign run_o = run_q;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
      end
      assign run_o = sh_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/acc_prog_rom.sv
module acc_prog_rom
  import acc_core_pkg::*;
(
  input  logic [PC_W-1:0]    addr_i,
  output logic [INSTR_W-1:0] word_o
);

  // Combinational program store
  always_comb word_o = prog_word(addr_i);

endmodule

// File: rtl/acc_decode.sv
module acc_decode
  import acc_core_pkg::*;
(
  input  logic [INSTR_W-1:0]   word_i,
  input  logic                 zero_i,
  output logic [OP_W-1:0]      op_o,
  output logic [REG_IDX_W-1:0] ridx_o,
  output logic [FIELD_W-1:0]   field_o,
  output ctrl_t                ctrl_o
);

  assign op_o    = word_i[INSTR_W-1 -: OP_W];
  assign ridx_o  = word_i[RIDX_LSB +: REG_IDX_W];
  assign field_o = word_i[FIELD_W-1:0];

  always_comb begin
    ctrl_o = '0;
    case (op_o)
      OPC_JMP:  ctrl_o.load_pc = 1'b1;
      OPC_BZ:   ctrl_o.load_pc = zero_i;
      OPC_STR:  ctrl_o.reg_we  = 1'b1;
      OPC_ADDI: begin
        ctrl_o.acc_we  = 1'b1;
        ctrl_o.use_add = 1'b1;
      end
      OPC_ANDR: ctrl_o.acc_we  = 1'b1;
      default:  ctrl_o = '0;  // no-op, PC only advances
    endcase
  end

endmodule

// File: rtl/acc_regfile.sv
module acc_regfile
  import acc_core_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [REG_IDX_W-1:0] idx_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [REGS_W-1:0]    flat_o
);

  generate
    for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
      logic              sel;
      logic [DATA_W-1:0] q;
      assign sel = we_i && (idx_i == REG_IDX_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (sel) q <= wdata_i;
      end
      assign flat_o[i*DATA_W +: DATA_W] = q;
    end
  endgenerate

  // Read port, same index as the write port
  assign rdata_o = flat_o[idx_i*DATA_W +: DATA_W];

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PC_W-1:0]   dbg_pc,
  output logic [DATA_W-1:0] dbg_acc,
  output logic              dbg_zero,
  output logic [REGS_W-1:0] dbg_regs
);

  logic                 run;
  logic [INSTR_W-1:0]   instr;
  logic [OP_W-1:0]      op;
  logic [REG_IDX_W-1:0] ridx;
  logic [FIELD_W-1:0]   field;
  ctrl_t                ctrl;
  logic [DATA_W-1:0]    rsel;

  logic [PC_W-1:0]      pc_q, pc_d;
  logic [DATA_W-1:0]    acc_q, acc_d;
  logic                 zero_q, zero_d;

  acc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .run_o (run)
  );

  acc_prog_rom u_rom (
    .addr_i (pc_q),
    .word_o (instr)
  );

  acc_decode u_dec (
    .word_i  (instr),
    .zero_i  (zero_q),
    .op_o    (op),
    .ridx_o  (ridx),
    .field_o (field),
    .ctrl_o  (ctrl)
  );

  acc_regfile u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (run && ctrl.reg_we),
    .idx_i   (ridx),
    .wdata_i (acc_q),
    .rdata_o (rsel),
    .flat_o  (dbg_regs)
  );

  // Next-state logic
  always_comb begin
    pc_d   = ctrl.load_pc ? field[PC_W-1:0] : pc_q + PC_W'(1);
    acc_d  = ctrl.use_add ? acc_q + field : acc_q & rsel;
    zero_d = (acc_d == '0);
  end

  // State registers, enabled once the release synchroniser is through
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      acc_q  <= '0;
      zero_q <= 1'b0;
    end else if (run) begin
      pc_q <= pc_d;
      if (ctrl.acc_we) begin
        acc_q  <= acc_d;
        zero_q <= zero_d;
      end
    end
  end

  assign dbg_pc   = pc_q;
  assign dbg_acc  = acc_q;
  assign dbg_zero = zero_q;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_core_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic [OP_W-1:0]   op,
  input logic [FIELD_W-1:0] field,
  input logic [PC_W-1:0]   pc,
  input logic [DATA_W-1:0] acc,
  input logic              zero,
  input logic [REGS_W-1:0] regs
);

  logic op_undef;
  assign op_undef = !(op == OPC_JMP || op == OPC_STR || op == OPC_ADDI ||
                      op == OPC_ANDR || op == OPC_BZ);

  // R1: state cleared while reset is held
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (pc == '0 && acc == '0 && !zero && regs == '0)
        else $error("reset state not clear");
    end
  end

  // R2: nothing moves before the synchroniser releases
  assert_hold_until_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pc == '0 && acc == '0));

  // R4
  assert_jump_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run && op == OPC_JMP |=> pc == $past(field[PC_W-1:0]));

  // R5
  assert_store_keeps_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run && op == OPC_STR |=> $stable(acc) && $stable(zero));

  // R6
  assert_add_imm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run && op == OPC_ADDI |=> acc == DATA_W'($past(acc) + $past(field)));

  // R8
  assert_branch_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run && op == OPC_BZ && zero |=> pc == $past(field[PC_W-1:0]));

  // R9
  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run && (op == OPC_ADDI || op == OPC_ANDR) |=> zero == (acc == '0));

  // R10
  assert_undef_noop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run && op_undef |=> $stable(acc) && $stable(zero) && $stable(regs));

  // R11: fall-through for everything but jump and branch (untaken branch included)
  assert_pc_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    run && op != OPC_JMP && !(op == OPC_BZ && zero) |=> pc == PC_W'($past(pc) + 1'b1));

endmodule

bind acc_core acc_core_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .run   (run),
  .op    (op),
  .field (field),
  .pc    (pc_q),
  .acc   (acc_q),
  .zero  (zero_q),
  .regs  (dbg_regs)
);

// File: tb/acc_core_bench.sv
`timescale 1ns/1ps
module acc_core_bench;
  import acc_core_pkg::*;

  typedef struct packed {
    logic [PC_W-1:0]   pc;
    logic [DATA_W-1:0] acc;
    logic              zero;
    logic [REGS_W-1:0] regs;
  } state_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [PC_W-1:0]   dbg_pc;
  logic [DATA_W-1:0] dbg_acc;
  logic              dbg_zero;
  logic [REGS_W-1:0] dbg_regs;

  int vectors = 0;
  int miscompares = 0;

  state_t exp_q[$];
  string  tag_q[$];
  state_t m;

  always #2 clk = ~clk;  // 250 MHz

  acc_core u_acc_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .dbg_pc   (dbg_pc),
    .dbg_acc  (dbg_acc),
    .dbg_zero (dbg_zero),
    .dbg_regs (dbg_regs)
  );

  task automatic compare(input string tag, input state_t e);
    vectors++;
    if (dbg_pc !== e.pc || dbg_acc !== e.acc || dbg_zero !== e.zero || dbg_regs !== e.regs) begin
      miscompares++;
      $display("FAIL %s: actual pc=%h acc=%h z=%b regs=%h expected pc=%h acc=%h z=%b regs=%h",
               tag, dbg_pc, dbg_acc, dbg_zero, dbg_regs, e.pc, e.acc, e.zero, e.regs);
    end
  endtask

  // Reference step derived from the instruction set rules (R3 field layout)
  task automatic model_step(output string tag);
    logic [INSTR_W-1:0]   w;
    logic [OP_W-1:0]      op;
    logic [REG_IDX_W-1:0] r;
    logic [FIELD_W-1:0]   f;
    logic [PC_W-1:0]      old_pc;
    logic                 redirect;
    w = prog_word(m.pc);
    op = w[15:12];
    r  = w[11:10];
    f  = w[7:0];
    old_pc = m.pc;
    redirect = 1'b0;
    case (op)
      OPC_JMP: begin m.pc = f; redirect = 1'b1; tag = "R4 jump"; end
      OPC_BZ: begin
        if (m.zero) begin m.pc = f; redirect = 1'b1; tag = "R8 branch taken"; end
        else tag = "R8 branch not taken";
      end
      OPC_STR: begin
        m.regs[int'(r)*DATA_W +: DATA_W] = m.acc;
        tag = "R5 store";
      end
      OPC_ADDI: begin
        m.acc = m.acc + f;
        m.zero = (m.acc == '0);
        tag = "R6 R9 add";
      end
      OPC_ANDR: begin
        m.acc = m.acc & m.regs[int'(r)*DATA_W +: DATA_W];
        m.zero = (m.acc == '0);
        tag = "R7 R9 and";
      end
      default: tag = "R10 undefined opcode";
    endcase
    if (!redirect) begin
      m.pc = old_pc + 1'b1;
      if (old_pc == 8'hFF) tag = {tag, " R11 wrap"};
      else tag = {tag, " R11"};
    end
  endtask

  // Driver: release reset away from edges and push the expected trace
  task automatic release_and_run(input int n);
    string t;
    @(posedge clk);
    #1 rst_n = 1'b1;
    m = '0;
    for (int k = 0; k < 3; k++) begin
      exp_q.push_back(m);
      tag_q.push_back("R2 release latency");
    end
    for (int k = 0; k < n; k++) begin
      model_step(t);
      exp_q.push_back(m);
      tag_q.push_back(t);
    end
  endtask

  // Monitor: one expected item per falling edge
  always @(negedge clk) begin : mon
    state_t e;
    string  t;
    if (exp_q.size() != 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compare(t, e);
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL R3 watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #0.5 compare("R1 power-on reset", '0);

    release_and_run(300);
    while (exp_q.size() != 0) @(negedge clk);

    // Asynchronous reset in the middle of a run
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5 compare("R1 mid-run reset immediate", '0);
    repeat (4) @(negedge clk);
    #0.5 compare("R1 reset held", '0);

    release_and_run(80);
    while (exp_q.size() != 0) @(negedge clk);
    #5;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule